// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting timer channel meant to be placed once for each CPU, each copy in its own 8-byte window of the address map. Software arms the channel with one 32-bit write. That write carries an enable bit, a mode bit that chooses one-shot or periodic operation, and a 29-bit start count. The count is encoded so that a programmed value V gives an expiry after V+1 ticks.

The channel counts down only in cycles where the tick-enable input from an outside prescaler is high. When the count expires, the channel raises a level interrupt that is active high. In periodic mode the channel then reloads its count and keeps running. In one-shot mode it turns itself off and holds the count at zero.

The interrupt stays high until software writes the clear bit in a second register. A read of that second register returns the remaining count and the pending flag.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the interrupt output is low, and reads at offset 0x0 and at offset 0x4 both return zero.
- R2: A write at offset 0x0 arms the channel. Bit 31 is the enable, bit 30 selects periodic mode (1) or one-shot mode (0), and bits 28:0 are the start count. A read at offset 0x0 returns the written word, except that bit 31 shows whether the channel is running now.
- R3: An enabled channel loaded with V expires on the (V+1)-th tick. Before that, the count in bits 28:0 of a read at offset 0x4 drops by one per tick.
- R4: Cycles with the tick-enable input low leave the count and the interrupt unchanged.
- R5: In one-shot mode, expiry clears the running state and holds the count at zero. Further ticks raise no further interrupt.
- R6: In periodic mode, expiry reloads V and counting goes on, so the channel expires again every V+1 ticks.
- R7: Expiry raises the interrupt output. The output stays high until it is cleared, and bit 30 of a read at offset 0x4 mirrors it.
- R8: A write at offset 0x4 with bit 30 set lowers the interrupt. A write at that offset with bit 30 clear has no effect.
- R9: If an expiry and a clear write fall in the same cycle, the interrupt stays high.
- R10: A write at offset 0x0 with bit 31 clear, including an all-zero word, stops counting. The count holds the written value, and a pending interrupt is left as it was.
- R11: The full 29-bit count 0x1fffffff loads and reads back intact. Writes to offsets other than 0x0 and 0x4 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte offset inside the channel window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench builds the channel with its defaults: a 29-bit count, a 3-bit offset, and the control and clear registers at 0x0 and 0x4. With these values the largest count, 0x1fffffff, can be loaded and read back directly. The small counts in the vector table reach expiry within a few ticks, so the reload in periodic mode and the self-stop in one-shot mode both fall inside short runs. Directed tests line up an expiry and a clear write in the same cycle, and also hit an unused offset in the 8-byte window.

// File: rtl/itc_pkg.sv
package itc_pkg;

  localparam int unsigned REG_W = 32;

  // Expiry: running, a tick this cycle, count at zero, and no load write competing.
  function automatic logic f_expires(input logic run, input logic tick,
                                     input logic at_zero, input logic load);
    return run & tick & at_zero & ~load;
  endfunction

  // One step of the down count.
  function automatic logic [REG_W-1:0] f_dec(input logic [REG_W-1:0] c);
    return c - 1'b1;
  endfunction

  // The next pending flag: an expiry beats a clear.
  function automatic logic f_irq_next(input logic cur, input logic expire,
                                      input logic clr);
    return expire | (cur & ~clr);
  endfunction

endpackage

// File: rtl/itc_regfile.sv
module itc_regfile #(
  parameter int unsigned CNT_W   = 29,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned EN_BIT  = 31,
  parameter int unsigned PER_BIT = 30,
  parameter int unsigned CLR_BIT = 30,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 3'h0,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 3'h4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [itc_pkg::REG_W-1:0] wdata_i,
  input  logic                     run_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     irq_i,
  output logic                     ev_load_o,
  output logic                     ev_clr_o,
  output logic                     load_en_o,
  output logic                     load_per_o,
  output logic [CNT_W-1:0]         load_val_o,
  output logic [itc_pkg::REG_W-1:0] rdata_o
);
  localparam int unsigned W = itc_pkg::REG_W;

  logic [W-1:0] ctrl_q;

  assign ev_load_o  = wr_en_i && (addr_i == CTRL_OFS);
  assign ev_clr_o   = wr_en_i && (addr_i == CLR_OFS) && wdata_i[CLR_BIT];
  assign load_en_o  = wdata_i[EN_BIT];
  assign load_per_o = wdata_i[PER_BIT];
  assign load_val_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ev_load_o) ctrl_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) begin
      rdata_o         = ctrl_q;
      rdata_o[EN_BIT] = run_i;
    end else if (addr_i == CLR_OFS) begin
      rdata_o[CNT_W-1:0] = cnt_i;
      rdata_o[CLR_BIT]   = irq_i;
    end
  end
endmodule

// File: rtl/itc_counter.sv
module itc_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             load_en_i,
  input  logic             load_per_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             run_o,
  output logic             per_o,
  output logic             expire_o
);
  import itc_pkg::*;

  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             run_q, per_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = f_expires(run_q, tick_i, at_zero, load_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      per_q    <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
      run_q    <= load_en_i;
      per_q    <= load_per_i;
    end else if (expire_o) begin
      if (per_q) cnt_q <= reload_q;
      else       run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= CNT_W'(f_dec(REG_W'(cnt_q)));
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign run_o    = run_q;
  assign per_o    = per_q;
endmodule

// File: rtl/itc_irq.sv
module itc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  output logic irq_o
);
  import itc_pkg::*;

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= f_irq_next(irq_q, expire_i, clr_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan #(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned PER_BIT = 30;
  localparam int unsigned CLR_BIT = 30;

  // Named internal events, brought out for the checker.
  logic             ev_load, ev_clr, ev_expire;
  logic             load_en, load_per;
  logic [CNT_W-1:0] load_val, cnt, reload;
  logic             run_en, periodic;

  itc_regfile #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT),
    .PER_BIT(PER_BIT), .CLR_BIT(CLR_BIT),
    .CTRL_OFS(ADDR_W'(0)), .CLR_OFS(ADDR_W'(4))
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .run_i(run_en), .cnt_i(cnt), .irq_i(irq_o),
    .ev_load_o(ev_load), .ev_clr_o(ev_clr), .load_en_o(load_en),
    .load_per_o(load_per), .load_val_o(load_val), .rdata_o(rdata_o)
  );

  itc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(ev_load),
    .load_en_i(load_en), .load_per_i(load_per), .load_val_i(load_val),
    .cnt_o(cnt), .reload_o(reload), .run_o(run_en), .per_o(periodic),
    .expire_o(ev_expire)
  );

  itc_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(ev_expire),
    .clr_i(ev_clr), .irq_o(irq_o)
  );
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int unsigned CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             irq,
  input logic             run_en,
  input logic             periodic,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             ev_expire,
  input logic             ev_clr,
  input logic             ev_load
);
  // R7: a rising interrupt always follows an expiry
  a_r7_rise_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_expire));

  // R7: a pending interrupt holds when no clear arrives
  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ev_clr) |=> irq);

  // R8: a clear with no competing expiry lowers the interrupt
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && !ev_expire) |=> !irq);

  // R9: an expiry wins over a clear in the same cycle
  a_r9_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && ev_clr) |=> irq);

  // R5: one-shot expiry stops the channel at zero
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && !periodic) |=> (!run_en && cnt == '0));

  // R6: periodic expiry reloads the programmed count
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_expire && periodic) |=> (run_en && cnt == $past(reload)));

  // R4: no tick and no load leaves the count alone
  a_r4_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ev_load) |=> $stable(cnt));
endmodule

bind interval_timer_chan itc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .tick(tick_i), .irq(irq_o),
  .run_en(run_en), .periodic(periodic), .cnt(cnt), .reload(reload),
  .ev_expire(ev_expire), .ev_clr(ev_clr), .ev_load(ev_load)
);

// File: tb/test_interval_timer_chan.sv
module test_interval_timer_chan;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // Vector table: mode, start count, ticks applied, expected irq, expected count.
  localparam logic        T_PER [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          T_VAL [NV] = '{3, 3, 5, 3, 3, 0, 0, 2};
  localparam int          T_NTK [NV] = '{3, 4, 2, 4, 6, 1, 5, 10};
  localparam logic        T_IRQ [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int          T_CNT [NV] = '{0, 0, 3, 3, 1, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer_chan i_interval_timer_chan (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'h0, v); check("R1 ctrl read", v, 32'd0);
    rst_n = 1'b1;
    rd(3'h4, v); check("R1 status read", v, 32'd0);

    // Table walk: R3, R5, R6, R7
    for (int k = 0; k < NV; k++) begin
      wr(3'h4, 32'h4000_0000);
      wr(3'h0, {1'b1, T_PER[k], 1'b0, 29'(T_VAL[k])});
      ticks(T_NTK[k]);
      rd(3'h4, v);
      check($sformatf("R3/R5/R6/R7 vec%0d irq", k), {31'd0, v[30]}, {31'd0, T_IRQ[k]});
      check($sformatf("R3/R5/R6 vec%0d count", k), {3'd0, v[28:0]}, 32'(T_CNT[k]));
      check($sformatf("R7 vec%0d pin", k), {31'd0, irq}, {31'd0, T_IRQ[k]});
    end

    // R2: arm and read back
    wr(3'h4, 32'h4000_0000);
    wr(3'h0, 32'hC000_0007);
    rd(3'h0, v); check("R2 ctrl readback", v, 32'hC000_0007);
    rd(3'h4, v); check("R2 count loaded", v, 32'h0000_0007);
    // R4: no ticks, nothing moves
    repeat (5) @(negedge clk);
    rd(3'h4, v); check("R4 count frozen", v, 32'h0000_0007);
    // R7: expire after 8 ticks
    ticks(8);
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    // R10: stop with zeros, pending irq kept
    wr(3'h0, 32'h0);
    rd(3'h0, v); check("R10 ctrl zero", v, 32'h0);
    ticks(3);
    check("R10 irq kept", {31'd0, irq}, 32'd1);
    // R8: clear bit zero has no effect, then real clear
    wr(3'h4, 32'hBFFF_FFFF);
    check("R8 no-op clear", {31'd0, irq}, 32'd1);
    wr(3'h4, 32'h4000_0000);
    check("R8 clear", {31'd0, irq}, 32'd0);
    // R10: disabled load keeps count
    wr(3'h0, 32'h0000_0009);
    ticks(4);
    rd(3'h4, v); check("R10 disabled holds", v, 32'h0000_0009);
    // R5: one-shot self stop
    wr(3'h0, 32'h8000_0001);
    ticks(2);
    check("R5 expiry irq", {31'd0, irq}, 32'd1);
    rd(3'h0, v); check("R5 enable dropped", v, 32'h0000_0001);
    wr(3'h4, 32'h4000_0000);
    ticks(5);
    rd(3'h4, v); check("R5 no re-fire", v, 32'h0);
    // R9: expiry and clear in the same cycle
    wr(3'h0, 32'h8000_0000);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'h4; wdata = 32'h4000_0000;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R9 expiry wins", {31'd0, irq}, 32'd1);
    wr(3'h4, 32'h4000_0000);
    check("R9 later clear", {31'd0, irq}, 32'd0);
    // R11: full range and unused offset
    wr(3'h0, 32'h1FFF_FFFF);
    rd(3'h4, v); check("R11 max count", v, 32'h1FFF_FFFF);
    wr(3'h2, 32'h8000_0003);
    rd(3'h0, v); check("R11 stray write ignored", v, 32'h1FFF_FFFF);
    rd(3'h2, v); check("R11 stray read zero", v, 32'h0);
    wr(3'h0, 32'h9FFF_FFFF);
    ticks(2);
    rd(3'h4, v); check("R11 max count decrements", v, 32'h1FFF_FFFD);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule